// File: doc/BRIEF.md
# Dual-Mode Baud Tick Generator

This block derives the 16x oversampling strobe that a serial transmitter and receiver use, working from the system clock. One 16-bit divisor word serves two algorithms, picked by a mode input. With the mode low, an integer period counter fires the strobe once every N clocks, where N is the divisor (system clock over sixteen times the bit rate). With the mode high, a 16-bit phase accumulator adds the divisor on every clock and its carry out becomes the strobe. The divisor is then sixteen times the bit rate times 2^16 over the clock. This mode is the better choice above 19200 baud, and the integer mode is the better choice below it.

A run input starts and freezes the generator. Dropping it clears every piece of internal state, so a restart always begins a clean period. A second divider counts sixteen oversampling strobes and emits a bit-period strobe. Both outputs are registered pulses one clock wide.

Top module: `dualBaudGen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both ovsTick and bitTick are low.
- R2: In integer mode (accMode = 0) with divisor N >= 2, ovsTick is high for one cycle every N clocks. The first pulse shows N clocks after the first rising edge that samples runEn high.
- R3: In integer mode a divisor of 0 or 1 makes ovsTick high on every clock while running.
- R4: In accumulator mode (accMode = 1), each clock adds reloadVal to a 16-bit accumulator that starts from zero, and ovsTick is the registered carry. For example, 0x4000 gives a pulse every 4 clocks, and 0x6000 gives pulses on clocks 3, 6 and 8.
- R5: While runEn is low, no ticks come out, and the period counter, accumulator and bit divider are held at zero. After a restart, the first pulse comes a full period later.
- R6: In integer mode, a divisor written while running is taken at the next ovsTick. The period in progress keeps the old value.
- R7: In accumulator mode, a divisor written while running is used from the very next clock.
- R8: bitTick pulses for one cycle on the clock after every 16th ovsTick counted since the generator started. Stopping the generator clears that count.
- R9: Changing accMode while running spends one clock clearing all state with no tick. The new mode then starts from zero.
- R10: Each ovsTick and bitTick pulse lasts one cycle, except where R3 or a carry on every clock calls for back-to-back ovsTick pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Run enable; low freezes and clears the generator |
| accMode | input | 1 | 0 = integer divide, 1 = phase accumulator |
| reloadVal | input | REG_W | Divisor or phase increment |
| ovsTick | output | 1 | Oversampling strobe |
| bitTick | output | 1 | Bit-period strobe, one per OVS oversampling strobes |

## Verification
The bench builds the block with its defaults: a 16-bit divisor and an oversampling ratio of 16. With these values, divisors of 0 and 1 and accumulator increments on either side of half scale can be applied directly, so every-clock ticks, carry patterns and mid-period writes all show up within a few dozen clocks. With an oversampling ratio of 16 and a divisor of 1, the bit strobe appears after 17 clocks. This makes it practical to check the clearing of the bit count on a stop.

// File: rtl/dualBaudPkg.sv
package dualBaudPkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic clear;    // zero counter, accumulator, bit divider; latch divisor
    logic intStep;  // advance the integer period counter
    logic accStep;  // advance the phase accumulator
  } genStrobe_t;

endpackage

// File: rtl/dualBaudCtrl.sv
module dualBaudCtrl
  import dualBaudPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic       accMode,
  output genStrobe_t strobe
);

  logic modePrev;
  logic modeFlip;

  // Remember the mode seen on the last edge so a switch can be detected
  always_ff @(posedge clk) begin
    if (!rstN) modePrev <= 1'b0;
    else       modePrev <= accMode;
  end

  assign modeFlip = runEn && (accMode != modePrev);

  always_comb begin
    strobe.clear   = !runEn || modeFlip;
    strobe.intStep = runEn && !modeFlip && !accMode;
    strobe.accStep = runEn && !modeFlip &&  accMode;
  end

endmodule

// File: rtl/dualBaudDatapath.sv
module dualBaudDatapath
  import dualBaudPkg::*;
#(
  parameter int REG_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  genStrobe_t       strobe,
  input  logic [REG_W-1:0] reloadVal,
  output logic             ovsTick,
  output logic             bitTick
);

  localparam int BCW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [BCW-1:0] BIT_LAST = BCW'(OVS - 1);

  // Integer divider state
  logic [REG_W-1:0] cnt;
  logic [REG_W-1:0] periodQ;
  logic [REG_W:0]   cntNext;
  logic             intHit;

  // Phase accumulator state
  logic [REG_W-1:0] acc;
  logic [REG_W:0]   accSum;

  // Bit-period divider state
  logic [BCW-1:0]   bitCnt;
  logic             ovsQ;
  logic             bitQ;

  assign cntNext = {1'b0, cnt} + {{REG_W{1'b0}}, 1'b1};
  assign intHit  = cntNext >= {1'b0, periodQ};
  assign accSum  = {1'b0, acc} + {1'b0, reloadVal};

  // Integer divider: counts up to the divisor latched at the last wrap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      periodQ <= '0;
    end else if (strobe.clear) begin
      cnt     <= '0;
      periodQ <= reloadVal;
    end else if (strobe.intStep) begin
      if (intHit) begin
        cnt     <= '0;
        periodQ <= reloadVal;
      end else begin
        cnt     <= cntNext[REG_W-1:0];
      end
    end
  end

  // Phase accumulator: increment taken straight from the port
  always_ff @(posedge clk) begin
    if (!rstN)              acc <= '0;
    else if (strobe.clear)  acc <= '0;
    else if (strobe.accStep) acc <= accSum[REG_W-1:0];
  end

  // Oversampling strobe register
  always_ff @(posedge clk) begin
    if (!rstN)               ovsQ <= 1'b0;
    else if (strobe.clear)   ovsQ <= 1'b0;
    else if (strobe.intStep) ovsQ <= intHit;
    else if (strobe.accStep) ovsQ <= accSum[REG_W];
    else                     ovsQ <= 1'b0;
  end

  // Bit-period divider driven by the registered oversampling strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      bitQ   <= 1'b0;
    end else if (strobe.clear) begin
      bitCnt <= '0;
      bitQ   <= 1'b0;
    end else if (ovsQ) begin
      if (bitCnt == BIT_LAST) begin
        bitCnt <= '0;
        bitQ   <= 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
        bitQ   <= 1'b0;
      end
    end else begin
      bitQ <= 1'b0;
    end
  end

  assign ovsTick = ovsQ;
  assign bitTick = bitQ;

endmodule

// File: rtl/dualBaudGen.sv
module dualBaudGen #(
  parameter int REG_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             accMode,
  input  logic [REG_W-1:0] reloadVal,
  output logic             ovsTick,
  output logic             bitTick
);

  dualBaudPkg::genStrobe_t strobe;

  dualBaudCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .runEn   (runEn),
    .accMode (accMode),
    .strobe  (strobe)
  );

  dualBaudDatapath #(
    .REG_W (REG_W),
    .OVS   (OVS)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reloadVal (reloadVal),
    .ovsTick   (ovsTick),
    .bitTick   (bitTick)
  );

endmodule

// File: rtl/dualBaudGenChk.sv
module dualBaudGenChk #(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             runEn,
  input logic             accMode,
  input logic [REG_W-1:0] reloadVal,
  input logic             ovsTick,
  input logic             bitTick
);

  localparam logic [REG_W-1:0] HALF = {1'b1, {(REG_W-1){1'b0}}};

  // R5
  stop_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!ovsTick && !bitTick));

  // R8
  bit_follows_ovs_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> $past(ovsTick));

  // R10
  bit_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |=> !bitTick);

  // R2
  int_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovsTick && !accMode && !$past(accMode) && ($past(reloadVal) > 1))
      |=> !ovsTick);

  // R4
  acc_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovsTick && accMode && $past(accMode) && ($past(reloadVal) < HALF)
     && (reloadVal < HALF)) |=> !ovsTick);

endmodule

bind dualBaudGen dualBaudGenChk #(.REG_W(REG_W)) uChk (.*);

// File: tb/sim_dualBaudGen.sv
module sim_dualBaudGen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic        accMode = 1'b0;
  logic [15:0] reloadVal = 16'd0;
  logic        ovsTick;
  logic        bitTick;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #10ns clk = ~clk;

  dualBaudGen #(.REG_W(16), .OVS(16)) u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .accMode(accMode),
    .reloadVal(reloadVal), .ovsTick(ovsTick), .bitTick(bitTick)
  );

  // Sample n cycles of one output at negedges, compare to a bit mask
  task automatic watch(input bit selBit, input int n, input logic [63:0] exp,
                       input string tag);
    logic [63:0] got = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      got[i] = selBit ? bitTick : ovsTick;
    end
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: %s pattern actual %h expected %h", tag,
               selBit ? "bitTick" : "ovsTick", got, exp);
    end
  endtask

  task automatic stopGen();
    @(negedge clk); runEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic prep(input logic mode, input logic [15:0] val);
    stopGen();
    accMode = mode; reloadVal = val;
    @(negedge clk); runEn = 1'b1;
  endtask

  task automatic testReset();
    @(negedge clk);
    testCount++;
    if (ovsTick !== 1'b0 || bitTick !== 1'b0) begin
      failCount++;
      $display("FAIL R1: reset outputs actual %b%b expected 00", ovsTick, bitTick);
    end
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    testCount++;
    if (ovsTick !== 1'b0 || bitTick !== 1'b0) begin
      failCount++;
      $display("FAIL R1: post-reset outputs actual %b%b expected 00", ovsTick, bitTick);
    end
  endtask

  task automatic testIntPeriod();
    prep(1'b0, 16'd5);
    watch(0, 20, 64'h84210, "R2 divisor 5");      // R10 gaps between pulses
    prep(1'b0, 16'd2);
    watch(0, 8, 64'hAA, "R2 divisor 2");
  endtask

  task automatic testIntSmall();
    prep(1'b0, 16'd0);
    watch(0, 8, 64'hFF, "R3 divisor 0");
    prep(1'b0, 16'd1);
    watch(0, 8, 64'hFF, "R3 divisor 1");
  endtask

  task automatic testAcc();
    prep(1'b1, 16'h4000);
    watch(0, 16, 64'h8888, "R4 inc 0x4000");
    prep(1'b1, 16'h6000);
    watch(0, 8, 64'hA4, "R4 inc 0x6000");
  endtask

  task automatic testStop();
    prep(1'b0, 16'd1);
    watch(0, 4, 64'hF, "R5 running before stop");
    runEn = 1'b0;
    watch(0, 10, 64'h0, "R5 silent while stopped");
    reloadVal = 16'd5;
    @(negedge clk); runEn = 1'b1;
    watch(0, 10, 64'h210, "R5 full period after restart");
  endtask

  task automatic testIntWrite();
    prep(1'b0, 16'd4);
    watch(0, 5, 64'h8, "R6 before write");
    reloadVal = 16'd7;
    watch(0, 17, 64'h10204, "R6 write applied at next tick");
  endtask

  task automatic testAccWrite();
    prep(1'b1, 16'h4000);
    watch(0, 5, 64'h8, "R7 before write");
    reloadVal = 16'h8000;
    watch(0, 4, 64'hA, "R7 write applied at once");
  endtask

  task automatic testBitTick();
    prep(1'b0, 16'd1);
    watch(1, 40, 64'h1_0001_0000, "R8 bit strobe every 16");
    prep(1'b0, 16'd1);
    watch(1, 10, 64'h0, "R8 partial count");
    runEn = 1'b0;
    @(negedge clk);
    @(negedge clk); runEn = 1'b1;
    watch(1, 20, 64'h1_0000, "R8 count cleared by stop");
  endtask

  task automatic testModeSwitch();
    prep(1'b0, 16'd5);
    watch(0, 7, 64'h10, "R9 integer phase");
    accMode = 1'b1; reloadVal = 16'h4000;
    watch(0, 9, 64'h110, "R9 accumulator restarts from zero");
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    finished = 1'b1;
    $finish;
  endtask

  initial begin
    testReset();
    testIntPeriod();
    testIntSmall();
    testAcc();
    testStop();
    testIntWrite();
    testAccWrite();
    testBitTick();
    testModeSwitch();
    finishRun();
  end

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: run hung, actual running expected done");
      finishRun();
    end
  end

endmodule